// File: doc/BRIEF.md
# SMM Memory Window Controller

This block holds the two control bytes that govern system-management memory in a host bridge: a primary control byte (open, lock, global enable) and an extended control byte (high-alias select, TSEG enable, TSEG size code). Software updates them one byte at a time through a configuration write port. Each register has a write mask. Once the lock bit is set, a reduced mask is used until reset, so the settings can no longer change.

From the stored bytes the block drives one enable per memory window for the system fabric. The windows are the legacy window opened to ordinary agents, the high alias opened to ordinary agents, the legacy range routed to the PCI/video side, the SMM-only low and high windows, and the TSEG window and TSEG blackhole. It also computes the TSEG size in megabytes and its base address below a configured top of low memory. For each access it checks whether a non-SMM agent has hit the active TSEG range. It answers such reads with all ones and flags such writes for discard. A 16-bit query register lets firmware discover the extended TSEG size.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset the primary and extended control bytes read 0x00, the query register reads 0xFFFF when EXT_MB is nonzero, every window enable is low except the legacy-to-PCI route, and the TSEG size is 0.
- R2: Register addresses are 0 (primary), 1 (extended), 2 (query low byte) and 3 (query high byte). Primary bit 0 is open, bit 1 is lock, bit 2 is global enable. Extended bit 0 is high-alias select, bits 2:1 are the size code and bit 3 is TSEG enable. Unused bits read 0.
- R3: A write that sets lock clears open in the same update. From then until reset, writes to the primary and extended bytes have no effect.
- R4: For non-SMM agents, the low window opens when open=1 and high-select=0, and the high alias opens when open=1 and high-select=1. The legacy-to-PCI route is active whenever the low window is not open.
- R5: For SMM agents, the low window is enabled when global enable=1 and high-select=0, and the high window when global enable=1 and high-select=1. Neither is enabled when global enable=0.
- R6: With TSEG enabled, size code 0 gives 1 MB, code 1 gives 2 MB, code 2 gives 8 MB and code 3 gives EXT_MB megabytes. With TSEG disabled the size is 0, and both TSEG enables follow size≠0.
- R7: The TSEG base equals TOLM minus the size in bytes, and the region ends at TOLM.
- R8: A non-SMM access of 1 to 4 bytes whose address lies in [base, TOLM) of an active TSEG is a hit. A hit read returns 0xFFFFFFFF and a hit write is flagged as dropped. SMM accesses, other sizes and out-of-range addresses never hit.
- R9: If a byte write leaves the query register equal to 0xFFFF, the register is loaded with EXT_MB. Any other value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte for cfg_addr |
| win_low_open | output | 1 | Legacy window visible to non-SMM agents as RAM |
| win_high_open | output | 1 | High alias visible to non-SMM agents |
| win_legacy_pci | output | 1 | Legacy range routed to PCI/video |
| win_smm_low | output | 1 | Legacy window visible to SMM |
| win_smm_high | output | 1 | High alias visible to SMM |
| tseg_win_en | output | 1 | TSEG window visible to SMM |
| tseg_hole_en | output | 1 | TSEG blackhole in force for non-SMM |
| tseg_mb | output | 16 | TSEG size in megabytes |
| tseg_base | output | ADDR_W | TSEG base address |
| acc_valid | input | 1 | Access present |
| acc_smm | input | 1 | Access issued in SMM |
| acc_wr | input | 1 | Access is a write |
| acc_bytes | input | 3 | Access size in bytes |
| acc_addr | input | ADDR_W | Access address |
| acc_hit | output | 1 | Access hit the blackhole |
| acc_wr_drop | output | 1 | Hit write to be discarded |
| acc_rdata | output | 32 | Blackhole read data |

## Verification
The window decode is tried with a table that walks every combination of open, global enable and high-select that matters. This shows that the non-SMM and SMM paths use different control bits and that high-select moves each path between its two windows. The same table steps through all four size codes and through writes with the unused bits set, which tells the fixed sizes apart from the parameter size and shows the masks. Directed cases probe the first and last byte of TSEG and the bytes just outside it, SMM against non-SMM accesses, and illegal sizes. They also cover a lock set together with open, and query writes that do and do not form the magic word.

// File: rtl/smm_pkg.sv
package smm_pkg;
   typedef struct packed {
      logic gen;
      logic lock;
      logic open;
   } smram_t;

   typedef struct packed {
      logic       tseg_en;
      logic [1:0] sz;
      logic       hi_en;
   } esmram_t;

   typedef enum logic [1:0] {
      TSZ_1M  = 2'd0,
      TSZ_2M  = 2'd1,
      TSZ_8M  = 2'd2,
      TSZ_EXT = 2'd3
   } tseg_code_e;

   localparam logic [1:0] RA_SMRAM  = 2'd0;
   localparam logic [1:0] RA_EXT    = 2'd1;
   localparam logic [1:0] RA_QRY_LO = 2'd2;
   localparam logic [1:0] RA_QRY_HI = 2'd3;

   localparam logic [2:0] SM_WMASK      = 3'b111;
   localparam logic [2:0] SM_WMASK_LCK  = 3'b000;
   localparam logic [3:0] EXT_WMASK     = 4'hF;
   localparam logic [3:0] EXT_WMASK_LCK = 4'h0;
endpackage

// File: rtl/smm_regs.sv
module smm_regs
   import smm_pkg::*;
#(
   parameter int unsigned EXT_MB    = 16,
   parameter logic [15:0] QUERY_VAL = 16'hFFFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output smram_t     sm_q,
   output esmram_t    ext_q,
   output logic [7:0] rdata
);
   localparam logic [15:0] EXT_MB_W = 16'(EXT_MB);

   logic [2:0] sm_mask;
   logic [3:0] ext_mask;
   smram_t     sm_nxt;
   esmram_t    ext_nxt;
   logic [15:0] qry_q;

   always_comb begin
      sm_mask  = sm_q.lock ? SM_WMASK_LCK  : SM_WMASK;
      ext_mask = sm_q.lock ? EXT_WMASK_LCK : EXT_WMASK;
      sm_nxt   = sm_q;
      ext_nxt  = ext_q;
      if (wr && addr == RA_SMRAM)
         sm_nxt = smram_t'((3'(sm_q) & ~sm_mask) | (wdata[2:0] & sm_mask));
      if (wr && addr == RA_EXT)
         ext_nxt = esmram_t'((4'(ext_q) & ~ext_mask) | (wdata[3:0] & ext_mask));
      if (sm_nxt.lock)
         sm_nxt.open = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sm_q  <= '0;
         ext_q <= '0;
      end else begin
         sm_q  <= sm_nxt;
         ext_q <= ext_nxt;
      end
   end

   generate
      if (EXT_MB > 0) begin : g_qry
         logic [15:0] qry_nxt;
         always_comb begin
            qry_nxt = qry_q;
            if (wr && addr == RA_QRY_LO) qry_nxt[7:0]  = wdata;
            if (wr && addr == RA_QRY_HI) qry_nxt[15:8] = wdata;
            if (wr && (addr == RA_QRY_LO || addr == RA_QRY_HI) && qry_nxt == QUERY_VAL)
               qry_nxt = EXT_MB_W;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) qry_q <= QUERY_VAL;
            else        qry_q <= qry_nxt;
         end
      end else begin : g_noqry
         assign qry_q = '0;
      end
   endgenerate

   always_comb begin
      unique case (addr)
         RA_SMRAM:  rdata = {5'b0, 3'(sm_q)};
         RA_EXT:    rdata = {4'b0, 4'(ext_q)};
         RA_QRY_LO: rdata = qry_q[7:0];
         default:   rdata = qry_q[15:8];
      endcase
   end
endmodule

// File: rtl/smm_tseg_calc.sv
module smm_tseg_calc
   import smm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h8000_0000,
   parameter int unsigned EXT_MB = 16
) (
   input  esmram_t           ext_q,
   output logic [15:0]       mb,
   output logic [ADDR_W-1:0] base,
   output logic              active
);
   localparam int unsigned MB_SHIFT = 20;

   always_comb begin
      if (!ext_q.tseg_en) begin
         mb = 16'd0;
      end else begin
         unique case (tseg_code_e'(ext_q.sz))
            TSZ_1M:  mb = 16'd1;
            TSZ_2M:  mb = 16'd2;
            TSZ_8M:  mb = 16'd8;
            default: mb = 16'(EXT_MB);
         endcase
      end
      active = (mb != 16'd0);
      base   = TOLM - (ADDR_W'(mb) << MB_SHIFT);
   end
endmodule

// File: rtl/smm_vis_decode.sv
module smm_vis_decode
   import smm_pkg::*;
(
   input  smram_t  sm_q,
   input  esmram_t ext_q,
   output logic    low_open,
   output logic    high_open,
   output logic    legacy_pci,
   output logic    smm_low,
   output logic    smm_high
);
   always_comb begin
      low_open   = sm_q.open & ~ext_q.hi_en;
      high_open  = sm_q.open &  ext_q.hi_en;
      legacy_pci = ~low_open;
      smm_low    = sm_q.gen  & ~ext_q.hi_en;
      smm_high   = sm_q.gen  &  ext_q.hi_en;
   end
endmodule

// File: rtl/smm_hole_resp.sv
module smm_hole_resp #(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h8000_0000,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MAX_BYTES = 4
) (
   input  logic              active,
   input  logic [ADDR_W-1:0] base,
   input  logic              acc_valid,
   input  logic              acc_smm,
   input  logic              acc_wr,
   input  logic [2:0]        acc_bytes,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              hit,
   output logic              wr_drop,
   output logic [DATA_W-1:0] rdata
);
   logic size_ok, in_rng;

   always_comb begin
      size_ok = (acc_bytes != 3'd0) && (32'(acc_bytes) <= MAX_BYTES);
      in_rng  = (acc_addr >= base) && (acc_addr < TOLM);
      hit     = acc_valid && !acc_smm && active && size_ok && in_rng;
      wr_drop = hit && acc_wr;
      rdata   = (hit && !acc_wr) ? '1 : '0;
   end
endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
   import smm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h8000_0000,
   parameter int unsigned EXT_MB     = 16,
   parameter int unsigned EXT_MB_MAX = 4095,
   parameter logic [15:0] QUERY_VAL  = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              win_low_open,
   output logic              win_high_open,
   output logic              win_legacy_pci,
   output logic              win_smm_low,
   output logic              win_smm_high,
   output logic              tseg_win_en,
   output logic              tseg_hole_en,
   output logic [15:0]       tseg_mb,
   output logic [ADDR_W-1:0] tseg_base,
   input  logic              acc_valid,
   input  logic              acc_smm,
   input  logic              acc_wr,
   input  logic [2:0]        acc_bytes,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              acc_hit,
   output logic              acc_wr_drop,
   output logic [31:0]       acc_rdata
);
   localparam longint unsigned MAX_FIX_MB = 8;
   localparam longint unsigned MAX_MB =
      (longint'(EXT_MB) > MAX_FIX_MB) ? longint'(EXT_MB) : MAX_FIX_MB;

   generate
      if (EXT_MB > EXT_MB_MAX) begin : g_bad_ext
         $error("EXT_MB above EXT_MB_MAX");
      end
      if (ADDR_W < 24 || ADDR_W > 48) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
      if ((MAX_MB << 20) > longint'(TOLM)) begin : g_bad_tolm
         $error("TOLM below largest TSEG size");
      end
   endgenerate

   smram_t  sm_q;
   esmram_t ext_q;
   logic    tseg_active;

   smm_regs #(.EXT_MB(EXT_MB), .QUERY_VAL(QUERY_VAL)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .sm_q(sm_q), .ext_q(ext_q), .rdata(cfg_rdata)
   );

   smm_vis_decode vis_i (
      .sm_q(sm_q), .ext_q(ext_q),
      .low_open(win_low_open), .high_open(win_high_open),
      .legacy_pci(win_legacy_pci), .smm_low(win_smm_low), .smm_high(win_smm_high)
   );

   smm_tseg_calc #(.ADDR_W(ADDR_W), .TOLM(TOLM), .EXT_MB(EXT_MB)) calc_i (
      .ext_q(ext_q), .mb(tseg_mb), .base(tseg_base), .active(tseg_active)
   );

   assign tseg_win_en  = tseg_active;
   assign tseg_hole_en = tseg_active;

   smm_hole_resp #(.ADDR_W(ADDR_W), .TOLM(TOLM), .DATA_W(32), .MAX_BYTES(4)) hole_i (
      .active(tseg_active), .base(tseg_base), .acc_valid(acc_valid),
      .acc_smm(acc_smm), .acc_wr(acc_wr), .acc_bytes(acc_bytes),
      .acc_addr(acc_addr), .hit(acc_hit), .wr_drop(acc_wr_drop), .rdata(acc_rdata)
   );
endmodule

// File: rtl/smm_window_ctrl_chk.sv
module smm_window_ctrl_chk
   import smm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] TOLM = 32'h8000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input smram_t            sm_q,
   input esmram_t           ext_q,
   input logic              win_low_open,
   input logic              win_high_open,
   input logic              win_smm_low,
   input logic              win_smm_high,
   input logic              tseg_win_en,
   input logic [ADDR_W-1:0] tseg_base,
   input logic              acc_smm,
   input logic              acc_wr,
   input logic              acc_hit,
   input logic [31:0]       acc_rdata
);
   a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sm_q.lock) |-> sm_q.lock);
   a_r3_open_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      sm_q.lock |-> !sm_q.open);
   a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sm_q.lock) |-> ($stable(ext_q) && $stable(sm_q.gen)));
   a_r4_open_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_low_open, win_high_open}));
   a_r5_smm_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_smm_low, win_smm_high}));
   a_r7_empty_base: assert property (@(posedge clk) disable iff (!rst_n)
      !tseg_win_en |-> tseg_base == TOLM);
   a_r8_smm_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      acc_smm |-> !acc_hit);
   a_r8_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && !acc_wr) |-> acc_rdata == 32'hFFFF_FFFF);
endmodule

bind smm_window_ctrl smm_window_ctrl_chk #(.ADDR_W(ADDR_W), .TOLM(TOLM)) chk_i (
   .clk(clk), .rst_n(rst_n), .sm_q(sm_q), .ext_q(ext_q),
   .win_low_open(win_low_open), .win_high_open(win_high_open),
   .win_smm_low(win_smm_low), .win_smm_high(win_smm_high),
   .tseg_win_en(tseg_win_en), .tseg_base(tseg_base),
   .acc_smm(acc_smm), .acc_wr(acc_wr), .acc_hit(acc_hit), .acc_rdata(acc_rdata)
);

// File: tb/smm_window_ctrl_tb_top.sv
module smm_window_ctrl_tb_top;
   localparam logic [31:0] TOLM = 32'h8000_0000;
   localparam int unsigned EXT_MB = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic win_low_open, win_high_open, win_legacy_pci, win_smm_low, win_smm_high;
   logic tseg_win_en, tseg_hole_en;
   logic [15:0] tseg_mb;
   logic [31:0] tseg_base;
   logic acc_valid = 1'b0, acc_smm = 1'b0, acc_wr = 1'b0;
   logic [2:0] acc_bytes = 3'd4;
   logic [31:0] acc_addr = '0;
   logic acc_hit, acc_wr_drop;
   logic [31:0] acc_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   smm_window_ctrl #(.TOLM(TOLM), .EXT_MB(EXT_MB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .win_low_open(win_low_open), .win_high_open(win_high_open),
      .win_legacy_pci(win_legacy_pci), .win_smm_low(win_smm_low),
      .win_smm_high(win_smm_high), .tseg_win_en(tseg_win_en),
      .tseg_hole_en(tseg_hole_en), .tseg_mb(tseg_mb), .tseg_base(tseg_base),
      .acc_valid(acc_valid), .acc_smm(acc_smm), .acc_wr(acc_wr),
      .acc_bytes(acc_bytes), .acc_addr(acc_addr), .acc_hit(acc_hit),
      .acc_wr_drop(acc_wr_drop), .acc_rdata(acc_rdata)
   );

   // [31:24] primary write, [23:16] extended write, [15:8] expected MB,
   // [4:0] expected {low_open, high_open, legacy_pci, smm_low, smm_high}
   localparam int NV = 10;
   localparam logic [31:0] VEC [NV] = '{
      32'h00_00_00_04, 32'h01_00_00_10, 32'h01_01_00_0C, 32'h04_00_00_06,
      32'h04_01_00_05, 32'h05_08_01_12, 32'h00_0A_02_04, 32'h00_0C_08_04,
      32'h00_0E_10_04, 32'hFC_F6_00_06
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [4:0] flags();
      return {win_low_open, win_high_open, win_legacy_pci, win_smm_low, win_smm_high};
   endfunction

   task automatic access(input logic smm, input logic w, input logic [2:0] nb,
                         input logic [31:0] a);
      acc_valid = 1'b1; acc_smm = smm; acc_wr = w; acc_bytes = nb; acc_addr = a;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(2'd0, rd); chk("R1 primary", 32'(rd), 32'h00);
      rd_reg(2'd1, rd); chk("R1 extended", 32'(rd), 32'h00);
      rd_reg(2'd2, rd); chk("R1 query lo", 32'(rd), 32'hFF);
      rd_reg(2'd3, rd); chk("R1 query hi", 32'(rd), 32'hFF);
      chk("R1 windows", 32'(flags()), 32'h04);
      chk("R1 tseg mb", 32'(tseg_mb), 32'd0);

      // R2 R4 R5 R6 table
      for (int i = 0; i < NV; i++) begin
         wr_reg(2'd0, VEC[i][31:24]);
         wr_reg(2'd1, VEC[i][23:16]);
         rd_reg(2'd0, rd); chk("R2 primary readback", 32'(rd), 32'(VEC[i][31:24] & 8'h07));
         rd_reg(2'd1, rd); chk("R2 extended readback", 32'(rd), 32'(VEC[i][23:16] & 8'h0F));
         chk("R4 R5 windows", 32'(flags()), 32'(VEC[i][4:0]));
         chk("R6 tseg mb", 32'(tseg_mb), 32'(VEC[i][15:8]));
         chk("R6 tseg enables", {30'b0, tseg_win_en, tseg_hole_en},
             (VEC[i][15:8] != 0) ? 32'h3 : 32'h0);
         chk("R7 tseg base", tseg_base, TOLM - (32'(VEC[i][15:8]) << 20));
      end

      // R8 blackhole, 8 MB TSEG -> base 0x7F80_0000
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd1, 8'h0C);
      chk("R7 base 8MB", tseg_base, 32'h7F80_0000);
      access(1'b0, 1'b0, 3'd4, 32'h7F80_0000);
      chk("R8 first byte hit", {acc_hit, acc_rdata[30:0]}, 32'hFFFF_FFFF);
      chk("R8 read ones", acc_rdata, 32'hFFFF_FFFF);
      access(1'b0, 1'b0, 3'd1, 32'h7F7F_FFFF);
      chk("R8 below base", {31'b0, acc_hit}, 32'd0);
      access(1'b0, 1'b0, 3'd4, 32'h7FFF_FFFC);
      chk("R8 last word", {31'b0, acc_hit}, 32'd1);
      access(1'b0, 1'b0, 3'd1, 32'h8000_0000);
      chk("R8 at TOLM", {31'b0, acc_hit}, 32'd0);
      access(1'b1, 1'b0, 3'd4, 32'h7F80_0000);
      chk("R8 smm no hit", {31'b0, acc_hit}, 32'd0);
      access(1'b0, 1'b1, 3'd2, 32'h7FA0_0000);
      chk("R8 write drop", {30'b0, acc_hit, acc_wr_drop}, 32'h3);
      chk("R8 write rdata", acc_rdata, 32'd0);
      access(1'b0, 1'b0, 3'd0, 32'h7FA0_0000);
      chk("R8 size 0", {31'b0, acc_hit}, 32'd0);
      access(1'b0, 1'b0, 3'd5, 32'h7FA0_0000);
      chk("R8 size 5", {31'b0, acc_hit}, 32'd0);
      wr_reg(2'd1, 8'h04);
      access(1'b0, 1'b0, 3'd4, 32'h7FF0_0000);
      chk("R8 tseg off", {31'b0, acc_hit}, 32'd0);
      acc_valid = 1'b0;

      // R3 lock
      wr_reg(2'd1, 8'h08);
      wr_reg(2'd0, 8'h01);
      chk("R3 pre-lock open", {31'b0, win_low_open}, 32'd1);
      wr_reg(2'd0, 8'h03);
      rd_reg(2'd0, rd); chk("R3 lock clears open", 32'(rd), 32'h02);
      chk("R3 window closed", {31'b0, win_low_open}, 32'd0);
      wr_reg(2'd0, 8'h05);
      rd_reg(2'd0, rd); chk("R3 primary frozen", 32'(rd), 32'h02);
      wr_reg(2'd1, 8'h0F);
      rd_reg(2'd1, rd); chk("R3 extended frozen", 32'(rd), 32'h08);
      chk("R3 tseg unchanged", 32'(tseg_mb), 32'd1);
      do_reset();
      rd_reg(2'd0, rd); chk("R3 reset unlocks", 32'(rd), 32'h00);
      wr_reg(2'd0, 8'h04);
      rd_reg(2'd0, rd); chk("R3 writable after reset", 32'(rd), 32'h04);

      // R9 query
      wr_reg(2'd2, 8'h34);
      wr_reg(2'd3, 8'h12);
      rd_reg(2'd2, rd); chk("R9 plain lo", 32'(rd), 32'h34);
      rd_reg(2'd3, rd); chk("R9 plain hi", 32'(rd), 32'h12);
      wr_reg(2'd3, 8'hFF);
      wr_reg(2'd2, 8'hFF);
      rd_reg(2'd2, rd); chk("R9 query lo", 32'(rd), 32'(EXT_MB & 8'hFF));
      rd_reg(2'd3, rd); chk("R9 query hi", 32'(rd), 32'(EXT_MB >> 8));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule